// File: doc/BRIEF.md
# Software-Driven Interrupt Status Controller

This block collects interrupt causes into a 32-bit pending mask and turns that mask into a notification for the host. Software adds causes by writing a value to a raise register. That value is ORed into the mask. Software removes causes by writing ones to an acknowledge register. Engines inside the same device, such as an arithmetic unit or a copy engine, set bits directly through a per-bit set vector. Software can read the current mask back at any time.

Two notification styles exist, selected by a mode input.

- **Legacy mode** is the reset default. It drives a level line that is high while any pending bit is set.
- **Message mode** keeps that line low. Instead, it emits a single-cycle strobe each time the mask gains a bit it did not hold before. The bus encoding of the message is left to the surrounding logic.

In both modes a cause stays pending until software acknowledges it. A driver therefore uses the same service routine regardless of mode.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the pending mask is zero, the level line is low and the strobe is low.
- R2: A read at offset 0x24 returns the pending mask in the cycle the address is presented. A read at any other offset returns zero.
- R3: A write at offset 0x60 ORs the written value into the pending mask at the next clock edge. Bits already pending stay set.
- R4: A write at offset 0x64 clears every mask bit that is one in the written value. Bits that are zero in the written value keep their state.
- R5: A write at any offset other than 0x60 and 0x64 leaves the pending mask unchanged.
- R6: Every bit that is high on the internal set vector in a cycle is pending after that cycle's clock edge, whether or not software writes at the same time.
- R7: When an internal set and an acknowledge clear target the same bit in the same cycle, the bit stays set.
- R8: With the mode input low (legacy), the level output is high exactly when the pending mask is nonzero, and the strobe stays low.
- R9: With the mode input high (message), the level output is low. The strobe is high for one cycle right after an edge where the mask gained at least one bit that was clear before. This covers both a zero-to-nonzero change and new bits added while others are pending. Raising bits that are already pending, or acknowledging bits, gives no strobe.
- R10: With no write and no internal set, the pending mask holds its value, including across a change of mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| src_set_i | input | 32 | Per-bit set requests from internal engines |
| msg_mode_i | input | 1 | 0: level notification, 1: message strobe |
| irq_level_o | output | 1 | Level interrupt line (legacy mode) |
| msg_strobe_o | output | 1 | One-cycle message interrupt strobe (message mode) |

## Verification
The hardest situation to reach from the ports is a cycle in which an engine sets a bit while software acknowledges that same bit. A driver normally acknowledges only after it has seen the bit, so ordinary traffic seldom lines up the two. The bench forces this overlap in a directed case and then raises the chance of it during random traffic, by drawing set and acknowledge masks from a small pool of bits. A second subtle case is a message-mode raise that adds new bits on top of a nonzero mask. This case must strobe, while a raise that adds only bits already pending must not. Both variants are driven on purpose.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_PEND  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_RAISE = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_ACK   = 8'h64;

    typedef logic [DATA_W-1:0] mask_t;

    typedef struct packed {
        mask_t pend;
    } core_state_t;

    typedef struct packed {
        logic strobe;
    } notify_state_t;
endpackage

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
    import irq_agg_pkg::*;
(
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  mask_t             wdata_i,
    input  mask_t             pend_i,
    output mask_t             raise_o,
    output mask_t             ack_o,
    output mask_t             rdata_o
);
    logic hit_raise;
    logic hit_ack;

    always_comb begin
        hit_raise = wr_en_i && (addr_i == OFF_RAISE);
        hit_ack   = wr_en_i && (addr_i == OFF_ACK);
        raise_o   = hit_raise ? wdata_i : '0;
        ack_o     = hit_ack   ? wdata_i : '0;
        rdata_o   = (addr_i == OFF_PEND) ? pend_i : '0;
    end
endmodule

// File: rtl/irq_agg_core.sv
module irq_agg_core
    import irq_agg_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  mask_t raise_i,
    input  mask_t ack_i,
    input  mask_t src_set_i,
    output mask_t pend_o,
    output mask_t pend_next_o
);
    core_state_t state_d, state_q;
    mask_t       next_bits;

    // Per-bit update: setting (software or engine) overrides clearing.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        always_comb begin
            if (raise_i[b] || src_set_i[b]) begin
                next_bits[b] = 1'b1;
            end else if (ack_i[b]) begin
                next_bits[b] = 1'b0;
            end else begin
                next_bits[b] = state_q.pend[b];
            end
        end
    end

    always_comb begin
        state_d      = state_q;
        state_d.pend = next_bits;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend_o      = state_q.pend;
    assign pend_next_o = state_d.pend;
endmodule

// File: rtl/irq_agg_notify.sv
module irq_agg_notify
    import irq_agg_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  msg_mode_i,
    input  mask_t pend_i,
    input  mask_t pend_next_i,
    output logic  irq_level_o,
    output logic  msg_strobe_o
);
    notify_state_t state_d, state_q;
    mask_t         gained;

    always_comb begin
        state_d        = state_q;
        gained         = pend_next_i & ~pend_i;
        state_d.strobe = msg_mode_i && (|gained);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_level_o  = !msg_mode_i && (|pend_i);
    assign msg_strobe_o = state_q.strobe;
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [DATA_W-1:0] src_set_i,
    input  logic              msg_mode_i,
    output logic              irq_level_o,
    output logic              msg_strobe_o
);
    mask_t raise_w;
    mask_t ack_w;
    mask_t pend_q;
    mask_t pend_d;

    irq_agg_regif u_regif (
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .pend_i  (pend_q),
        .raise_o (raise_w),
        .ack_o   (ack_w),
        .rdata_o (rdata_o)
    );

    irq_agg_core u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .raise_i     (raise_w),
        .ack_i       (ack_w),
        .src_set_i   (src_set_i),
        .pend_o      (pend_q),
        .pend_next_o (pend_d)
    );

    irq_agg_notify u_notify (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .msg_mode_i   (msg_mode_i),
        .pend_i       (pend_q),
        .pend_next_i  (pend_d),
        .irq_level_o  (irq_level_o),
        .msg_strobe_o (msg_strobe_o)
    );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] src_set_i,
    input logic              msg_mode_i,
    input logic [DATA_W-1:0] pend_q,
    input logic              irq_level_o,
    input logic              msg_strobe_o
);
    a_r3_raise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == OFF_RAISE) |=> ((pend_q & $past(wdata_i)) == $past(wdata_i)));

    a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == OFF_ACK && src_set_i == '0) |=> ((pend_q & $past(wdata_i)) == '0));

    a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_set_i != '0) |=> ((pend_q & $past(src_set_i)) == $past(src_set_i)));

    a_r8_legacy_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!msg_mode_i && !$past(msg_mode_i)) |-> !msg_strobe_o);

    a_r9_msg_no_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_mode_i |-> !irq_level_o);

    a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && src_set_i == '0) |=> $stable(pend_q));
endmodule

bind irq_agg_top irq_agg_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .src_set_i    (src_set_i),
    .msg_mode_i   (msg_mode_i),
    .pend_q       (pend_q),
    .irq_level_o  (irq_level_o),
    .msg_strobe_o (msg_strobe_o)
);

// File: tb/irq_agg_tb.sv
module irq_agg_top_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  addr_i = 8'h00;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [31:0] src_set_i = '0;
    logic        msg_mode_i = 1'b0;
    logic        irq_level_o;
    logic        msg_strobe_o;

    int unsigned n_tests = 0;
    int unsigned n_fail = 0;
    logic [31:0] exp_pend = '0;
    logic        exp_strobe = 1'b0;

    always #4 clk_i = ~clk_i;

    irq_agg_top dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .src_set_i(src_set_i),
        .msg_mode_i(msg_mode_i), .irq_level_o(irq_level_o), .msg_strobe_o(msg_strobe_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_pend(input logic [31:0] p, input logic we,
                                              input logic [7:0] a, input logic [31:0] d,
                                              input logic [31:0] s);
        logic [31:0] r = p;
        if (we && a == 8'h64) r = r & ~d;
        if (we && a == 8'h60) r = r | d;
        return r | s;
    endfunction

    // Apply one cycle of stimulus, update model, then check all outputs.
    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic [31:0] s, input string tag);
        logic [31:0] np;
        wr_en_i = we; addr_i = a; wdata_i = d; src_set_i = s;
        np = next_pend(exp_pend, we, a, d, s);
        exp_strobe = msg_mode_i && ((np & ~exp_pend) != 0);
        exp_pend = np;
        @(negedge clk_i);
        wr_en_i = 1'b0; src_set_i = '0; addr_i = 8'h24;
        #1;
        check({tag, " R2 pend read"}, rdata_o, exp_pend);
        check({tag, " R8/R9 level"}, {31'b0, irq_level_o}, {31'b0, !msg_mode_i && (exp_pend != 0)});
        check({tag, " R8/R9 strobe"}, {31'b0, msg_strobe_o}, {31'b0, exp_strobe});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk_i);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        addr_i = 8'h24;
        repeat (3) @(negedge clk_i);
        #1;
        check("R1 reset pend", rdata_o, 32'h0);
        check("R1 reset level", {31'b0, irq_level_o}, 32'h0);
        check("R1 reset strobe", {31'b0, msg_strobe_o}, 32'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // Directed: legacy
        step(1'b1, 8'h60, 32'h0000_0005, '0, "R3 raise");
        step(1'b1, 8'h60, 32'h0000_0100, '0, "R3 raise or");
        step(1'b1, 8'h64, 32'h0000_0004, '0, "R4 ack partial");
        step(1'b1, 8'h20, 32'hFFFF_FFFF, '0, "R5 other offset");
        addr_i = 8'h60; #1;
        check("R2 other read zero", rdata_o, 32'h0);
        step(1'b0, 8'h00, '0, 32'h0001_0000, "R6 internal set");
        step(1'b1, 8'h64, 32'h0001_0000, 32'h0001_0000, "R7 set wins");
        step(1'b0, 8'h00, '0, '0, "R10 hold");
        step(1'b1, 8'h64, 32'hFFFF_FFFF, '0, "R4 ack all");

        // Directed: message mode
        msg_mode_i = 1'b1;
        step(1'b1, 8'h60, 32'h0000_0002, '0, "R9 zero to nonzero");
        step(1'b1, 8'h60, 32'h0000_0002, '0, "R9 repeat no strobe");
        step(1'b1, 8'h60, 32'h0000_0008, '0, "R9 new while pending");
        step(1'b1, 8'h64, 32'h0000_0002, '0, "R9 ack no strobe");
        msg_mode_i = 1'b0;
        step(1'b0, 8'h00, '0, '0, "R10 mode switch hold");
        step(1'b1, 8'h64, 32'hFFFF_FFFF, '0, "R4 ack rest");

        // Random traffic, small bit pool to provoke overlaps
        for (int i = 0; i < 400; i++) begin
            logic [31:0] d, s, pool;
            logic [7:0]  a;
            int unsigned op;
            pool = (i % 2 == 0) ? 32'h0000_000F : 32'hFFFF_FFFF;
            if ($urandom_range(0, 15) == 0) msg_mode_i = ~msg_mode_i;
            op = $urandom_range(0, 4);
            d = $urandom() & pool;
            s = ($urandom_range(0, 2) == 0) ? ($urandom() & pool) : '0;
            case (op)
                0: a = 8'h60;
                1: a = 8'h64;
                2: a = 8'h24;
                default: a = 8'($urandom_range(0, 255));
            endcase
            step(op != 4, a, d, s, "R3/R4/R6/R7 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule